// File: doc/BRIEF.md
# Wrapping Counter with Multiple-of-Twelve Strobe

This block is a free-running up-counter that steps from 0 to 100000 and then returns to 0. Alongside the count it raises a strobe in every cycle where the registered count is an exact multiple of twelve. The strobe lets downstream logic act once every twelve counts without a second 0–11 counter.

The strobe is built from two tests. The two least significant count bits must both be zero, which gives divisibility by four. The remaining upper field must be divisible by three. The divisibility-by-three test uses the fact that four leaves a remainder of one when divided by three. The upper field is split into 2-bit digits, and the digits are summed pairwise in a balanced tree. After each addition the carry out of the pair is added back into the low bits (end-around carry), so every node stays two bits wide.

The tree is a parameterised module. Its digit width k sets the modulus to 2^k−1, which covers 3, 7 and 15. The counter's next action is chosen by a small enumerated step selector with three named steps:
- `STEP_HOLD`: taken when enable is low.
- `STEP_INC`: taken when enable is high and the count is below the limit.
- `STEP_WRAP`: taken when enable is high and the count is at the limit.

Synchronous reset overrides all three steps.

Top module: `mod12_tick_counter`

## Requirements
- R1: A clock edge with `rst` high sets `count_o` to 0. `tick_o` is then high, because 0 is a multiple of twelve.
- R2: With `en` high and `count_o` below 100000, the next clock edge makes `count_o` one greater (step `STEP_INC`).
- R3: With `en` high and `count_o` equal to 100000, the next clock edge makes `count_o` equal to 0 (step `STEP_WRAP`).
- R4: With `en` low, a clock edge leaves `count_o` unchanged (step `STEP_HOLD`). `tick_o` keeps the value that matches the held count.
- R5: In the same cycle, `tick_o` is high exactly when `count_o` mod 12 equals 0.
- R6: `count_o` never exceeds 100000.
- R7: The residue tree output equals x mod (2^k−1) for every 15-bit input x, with k = 2, 3 and 4. A folded node value of all ones is reported as residue 0.
- R8: The residue tree's zero flag is high exactly when x mod (2^k−1) equals 0. This includes the inputs whose folded value is all ones.
- R9: With k = 2, one fold stage gives residue 1 for digit pairs (3,1) and (1,3). These are the 4-bit inputs 0xD and 0x7, with the upper digit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low holds the count |
| count_o | output | 17 | Registered count value, 0 to 100000 |
| tick_o | output | 1 | High while `count_o` is a multiple of twelve |

## Verification
The clocked assertions assume that `rst` is high at the first clock edge, so every `$past` reference sees a defined count. They also assume that `en` is stable around each rising edge. The bench meets both assumptions: it holds reset high through the first edges and changes inputs only on falling edges. The arithmetic checks inside the residue tree assume an input narrower than 63 bits. The bench drives the tree with 15-bit values only.

// File: rtl/mod_res_pkg.sv
package mod_res_pkg;

    // Next action of the wrapping counter.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_WRAP = 2'd2
    } step_e;

    // Number of k-bit digits needed to cover a field of the given width.
    function automatic int digit_count(input int field_w, input int digit_w);
        return (field_w + digit_w - 1) / digit_w;
    endfunction

endpackage

// File: rtl/residue_fold.sv
// Adds two k-bit digits modulo 2^k-1 with an end-around carry.
module residue_fold #(
    parameter int DIGIT_W = 2
) (
    input  logic [DIGIT_W-1:0] a_i,
    input  logic [DIGIT_W-1:0] b_i,
    output logic [DIGIT_W-1:0] sum_o
);
    localparam int MODV = (1 << DIGIT_W) - 1;

    logic [DIGIT_W:0] raw_sum;

    always_comb begin
        raw_sum = {1'b0, a_i} + {1'b0, b_i};
        sum_o   = raw_sum[DIGIT_W-1:0] + DIGIT_W'(raw_sum[DIGIT_W]);
    end

    // R9
    always_comb begin
        fold_congruent_chk: assert ((int'(sum_o) % MODV) == ((int'(a_i) + int'(b_i)) % MODV))
            else $error("fold result not congruent to digit sum");
    end

endmodule

// File: rtl/residue_tree.sv
// Balanced tree of residue folds: value modulo 2^k-1.
module residue_tree #(
    parameter int IN_W    = 15,
    parameter int DIGIT_W = 2
) (
    input  logic [IN_W-1:0]    value_i,
    output logic [DIGIT_W-1:0] residue_o,
    output logic               is_zero_o
);
    import mod_res_pkg::*;

    localparam int NDIG   = digit_count(IN_W, DIGIT_W);
    localparam int LEAVES = 1 << $clog2(NDIG);
    localparam int PAD_W  = LEAVES * DIGIT_W;
    localparam int NODES  = 2 * LEAVES - 1;
    localparam int MODV   = (1 << DIGIT_W) - 1;
    localparam logic [DIGIT_W-1:0] ALL_ONES = '1;

    logic [PAD_W-1:0]   padded;
    logic [DIGIT_W-1:0] node [NODES];

    assign padded = PAD_W'(value_i);

    // Leaves occupy the upper half of the heap-ordered node array.
    for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
        assign node[LEAVES-1+l] = padded[l*DIGIT_W +: DIGIT_W];
    end

    // Each inner node folds its two children.
    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_fold
        residue_fold #(.DIGIT_W(DIGIT_W)) u_fold (
            .a_i  (node[2*n+1]),
            .b_i  (node[2*n+2]),
            .sum_o(node[n])
        );
    end

    always_comb begin
        residue_o = (node[0] == ALL_ONES) ? '0 : node[0];
        is_zero_o = (residue_o == '0);
    end

    // R7
    always_comb begin
        tree_residue_chk: assert (longint'(residue_o) == (longint'(value_i) % longint'(MODV)))
            else $error("tree residue differs from arithmetic modulus");
    end

    // R8
    always_comb begin
        tree_zero_chk: assert (is_zero_o == ((longint'(value_i) % longint'(MODV)) == 0))
            else $error("tree zero flag wrong");
    end

endmodule

// File: rtl/wrap_counter.sv
// Up-counter from 0 to CNT_MAX with hold and wrap.
module wrap_counter #(
    parameter int CNT_MAX = 100000,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o
);
    import mod_res_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    step_e            step;
    logic [CNT_W-1:0] cnt_q;

    // Step selection.
    always_comb begin
        if (!en)                 step = STEP_HOLD;
        else if (cnt_q == LIMIT) step = STEP_WRAP;
        else                     step = STEP_INC;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (step)
                STEP_HOLD: cnt_q <= cnt_q;
                STEP_INC:  cnt_q <= cnt_q + 1'b1;
                STEP_WRAP: cnt_q <= '0;
                default:   cnt_q <= '0;
            endcase
        end
    end

    assign cnt_o = cnt_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (cnt_q == '0))
        else $error("count not cleared by reset");

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q < LIMIT) |=> (cnt_q == $past(cnt_q) + 1'b1))
        else $error("count did not advance");

    // R3
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_q == LIMIT) |=> (cnt_q == '0))
        else $error("count did not wrap");

    // R4
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q))
        else $error("count moved while disabled");

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT)
        else $error("count above limit");

endmodule

// File: rtl/mod12_tick_counter.sv
// Top: wrapping counter plus multiple-of-twelve strobe.
module mod12_tick_counter #(
    parameter int CNT_MAX = 100000,
    parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o
);
    localparam int LOW_W   = 2;
    localparam int UPPER_W = CNT_W - LOW_W;
    localparam int MOD3_K  = 2;

    logic [CNT_W-1:0]  cnt;
    logic [MOD3_K-1:0] upper_res;
    logic              upper_div3;
    logic              low_div4;

    wrap_counter #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cnt_o(cnt)
    );

    residue_tree #(.IN_W(UPPER_W), .DIGIT_W(MOD3_K)) u_mod3 (
        .value_i  (cnt[CNT_W-1:LOW_W]),
        .residue_o(upper_res),
        .is_zero_o(upper_div3)
    );

    always_comb begin
        low_div4 = (cnt[LOW_W-1:0] == '0);
        tick_o   = low_div4 && upper_div3;
        count_o  = cnt;
    end

    // R5
    tick_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (count_o[1:0] == 2'b00))
        else $error("strobe with nonzero low bits");

    // R5
    tick_mod12_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o == ((int'(count_o) % 12) == 0))
        else $error("strobe disagrees with count mod 12");

    // R1
    tick_after_reset_chk: assert property (@(posedge clk) rst |=> tick_o)
        else $error("no strobe after reset");

endmodule

// File: tb/tb_mod12_tick_counter.sv
module tb_mod12_tick_counter;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_MAX    = 100000;
    localparam int CNT_W      = 17;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             tick_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mod12_tick_counter #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) dut (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .count_o(count_o),
        .tick_o (tick_o)
    );

    // Stand-alone residue trees for k = 2, 3, 4.
    logic [14:0] tv;
    logic [1:0]  r2;
    logic [2:0]  r3;
    logic [3:0]  r4;
    logic        z2, z3, z4;

    residue_tree #(.IN_W(15), .DIGIT_W(2)) u_t2 (.value_i(tv), .residue_o(r2), .is_zero_o(z2));
    residue_tree #(.IN_W(15), .DIGIT_W(3)) u_t3 (.value_i(tv), .residue_o(r3), .is_zero_o(z3));
    residue_tree #(.IN_W(15), .DIGIT_W(4)) u_t4 (.value_i(tv), .residue_o(r4), .is_zero_o(z4));

    logic [1:0] fa, fb, fs;
    residue_fold #(.DIGIT_W(2)) u_f2 (.a_i(fa), .b_i(fb), .sum_o(fs));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick_chk(input string req, input int exp_cnt);
        chk(count_o == CNT_W'(exp_cnt), req, "count", count_o, exp_cnt);
        chk(tick_o == ((exp_cnt % 12) == 0), "R5", "tick", tick_o, (exp_cnt % 12) == 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset();
        tick_chk("R1", 0);
    endtask

    // R2, R4: advance, then hold at a non-multiple and at a multiple.
    task automatic t_hold();
        do_reset();
        en = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            tick_chk("R2", i);
        end
        en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            tick_chk("R4", 5);
        end
        en = 1'b1;
        for (int i = 6; i <= 12; i++) begin
            @(negedge clk);
            tick_chk("R2", i);
        end
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tick_chk("R4", 12);
        end
    endtask

    // R1: reset in mid-run.
    task automatic t_reset_midrun();
        en = 1'b1;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        tick_chk("R1", 0);
        rst = 1'b0;
        @(negedge clk);
        tick_chk("R2", 1);
    endtask

    // R2, R3, R5, R6: one full sweep through the wrap.
    task automatic t_full_wrap();
        int exp_cnt;
        do_reset();
        en = 1'b1;
        exp_cnt = 0;
        for (int i = 0; i < CNT_MAX + 3; i++) begin
            @(negedge clk);
            exp_cnt = (exp_cnt == CNT_MAX) ? 0 : exp_cnt + 1;
            tick_chk((exp_cnt == 0) ? "R3" : "R2", exp_cnt);
            if (count_o > CNT_W'(CNT_MAX))
                chk(1'b0, "R6", "range", count_o, CNT_MAX);
        end
        total++;
    endtask

    // R7, R8: exhaustive residue sweep.
    task automatic t_tree_sweep();
        for (int v = 0; v < 32768; v++) begin
            tv = 15'(v);
            #1;
            chk(r2 == 2'(v % 3),  "R7", "k2", r2, v % 3);
            chk(r3 == 3'(v % 7),  "R7", "k3", r3, v % 7);
            chk(r4 == 4'(v % 15), "R7", "k4", r4, v % 15);
            chk(z2 == ((v % 3) == 0),  "R8", "z2", z2, (v % 3) == 0);
            chk(z3 == ((v % 7) == 0),  "R8", "z3", z3, (v % 7) == 0);
            chk(z4 == ((v % 15) == 0), "R8", "z4", z4, (v % 15) == 0);
        end
    endtask

    // R9: single fold corner pairs.
    task automatic t_fold_corner();
        fa = 2'd3; fb = 2'd1; #1;
        chk(fs == 2'd1, "R9", "0xD", fs, 1);
        fa = 2'd1; fb = 2'd3; #1;
        chk(fs == 2'd1, "R9", "0x7", fs, 1);
    endtask

    initial begin
        tv = '0;
        fa = '0;
        fb = '0;
        t_reset();
        t_hold();
        t_reset_midrun();
        t_fold_corner();
        t_tree_sweep();
        t_full_wrap();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule